// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a hardware watchdog. It counts down on its own clock, with no dependence on the processor it guards. Firmware proves it is alive by writing a two-word key into the service port before the count runs out. Once, during initialization, software chooses the timeout, the escalation mode and whether the watchdog runs. A lock input then freezes those settings. From then on no write can disable the watchdog or shorten or lengthen its period. Only a power-on reset lifts the lock.

When the count expires, or when a wrong key is written, the block escalates. In two-stage mode it first raises a non-maskable interrupt for a fixed grace period, which lets a handler log diagnostics, and then always forces a reset. In single-stage mode it goes to the reset at once. The reset phase drives the CPU reset, a peripheral reset and a safe-state output together, so that dangerous hardware is parked without help from software. It holds them for a minimum number of cycles, then releases them and starts counting again from the locked timeout.

When the reset phase begins, the block copies the real-time-clock input into a breadcrumb register that only power-on reset clears. Two status flags record that a watchdog reset happened and which escalation path led to it.

Top module: `wdog_lock_top`

## Requirements
- R1: The configuration port accepts exactly one write after power-on reset, provided the lock is not yet set. Every later configuration write leaves the readback of the timeout and the enable unchanged.
- R2: A pulse on the lock input sets the lock. After that, configuration writes are ignored. The lock stays set until power-on reset, and power-on reset clears it.
- R3: A service write of 0x5555 followed by a service write of 0xAAAA reloads the counter from the timeout T. After a reload, or after an enabling configuration write, the alarm begins on the (T+1)th clock if no further valid service arrives.
- R4: A service write of any other value expires the watchdog on the clock that accepts it. This includes 0xAAAA written without a preceding 0x5555.
- R5: In two-stage mode, expiry raises the interrupt output for exactly GRACE_CYC clocks, and then the reset phase follows unconditionally. Service writes during the grace period have no effect on this.
- R6: In single-stage mode, expiry enters the reset phase directly, and the interrupt output stays low.
- R7: In the reset phase, the CPU reset, the peripheral reset and the safe-state output are high together for HOLD_CYC clocks. HOLD_CYC is at least 16.
- R8: When the reset phase ends, the counter reloads from the locked timeout, and the next alarm begins on the (T+1)th clock.
- R9: On entry to the reset phase, the real-time-clock input is captured into the breadcrumb output. Later changes on that input and later watchdog resets leave it unchanged until the next capture. Power-on reset clears it to zero.
- R10: Entry to the reset phase sets the watchdog-reset flag. It also sets the interrupt-path flag to 1 if the grace stage came first and to 0 otherwise. A status-clear pulse clears both flags and leaves the breadcrumb unchanged.
- R11: After power-on reset, every alarm output is low, the lock is clear, the breadcrumb and the flags are zero, and the watchdog is idle.
- R12: A configuration written with the enable bit at 0 leaves the watchdog idle for good, and it never raises an alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock, independent of the CPU clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_timeout | input | TW | Timeout count T |
| cfg_two_stage | input | 1 | 1: interrupt then reset; 0: reset directly |
| cfg_enable | input | 1 | 1: run the watchdog |
| lock_set | input | 1 | Sets the configuration lock |
| svc_we | input | 1 | Service write strobe |
| svc_data | input | 16 | Service key value |
| stat_clr | input | 1 | Clears both status flags |
| rtc_time | input | RW | Real-time-clock value |
| nmi_o | output | 1 | Non-maskable interrupt during the grace stage |
| cpu_rst_o | output | 1 | Hard reset to the CPU |
| per_rst_o | output | 1 | Hard reset to the peripherals |
| safe_o | output | 1 | Safe-state command to dangerous hardware |
| locked_o | output | 1 | Configuration lock state |
| timeout_o | output | TW | Committed timeout readback |
| enable_o | output | 1 | Committed enable readback |
| crumb_o | output | RW | Breadcrumb: time of the last watchdog reset |
| stat_wd_o | output | 1 | Last reset came from the watchdog |
| stat_nmi_o | output | 1 | That reset came after the interrupt stage |

## Verification
The bench builds the block with a 16-bit timeout, a 32-bit time value, a grace period of 40 clocks and the minimum hold of 16 clocks. With these values every timing in the block can be counted exactly within a short run: the full interrupt-then-reset escalation, the release, and the reload that follows it. Each scenario starts from power-on reset, so the write-once configuration can be tried again with a different mode and different lock orderings.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_RUN   = 2'd1,
        WD_GRACE = 2'd2,
        WD_HOLD  = 2'd3
    } wd_state_e;
endpackage

// File: rtl/wdog_cfg.sv
`timescale 1ns/1ps
// Write-once configuration store with a sticky lock.
module wdog_cfg #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          cfg_we,
    input  logic [TW-1:0] cfg_timeout,
    input  logic          cfg_two_stage,
    input  logic          cfg_enable,
    input  logic          lock_set,
    output logic [TW-1:0] timeout_q,
    output logic          two_stage_q,
    output logic          enable_q,
    output logic          locked_q,
    output logic          load_o
);
    typedef struct packed {
        logic          written;
        logic          locked;
        logic [TW-1:0] timeout;
        logic          two_stage;
        logic          enable;
    } cfg_reg_t;

    cfg_reg_t r_q, r_d;
    logic     accept;

    always_comb begin
        r_d    = r_q;
        accept = cfg_we && !r_q.written && !r_q.locked;
        if (accept) begin
            r_d.written   = 1'b1;
            r_d.timeout   = cfg_timeout;
            r_d.two_stage = cfg_two_stage;
            r_d.enable    = cfg_enable;
        end
        if (lock_set) r_d.locked = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign timeout_q   = r_q.timeout;
    assign two_stage_q = r_q.two_stage;
    assign enable_q    = r_q.enable;
    assign locked_q    = r_q.locked;
    assign load_o      = accept;
endmodule

// File: rtl/wdog_key.sv
`timescale 1ns/1ps
// Two-word service key decoder: first word arms, second word services.
module wdog_key #(
    parameter int          KW    = 16,
    parameter logic [KW-1:0] KEY_A = 16'h5555,
    parameter logic [KW-1:0] KEY_B = 16'hAAAA
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          active,
    input  logic          svc_we,
    input  logic [KW-1:0] svc_data,
    output logic          kick_o,
    output logic          bad_o
);
    logic armed_q, armed_d;

    always_comb begin
        armed_d = armed_q;
        kick_o  = 1'b0;
        bad_o   = 1'b0;
        if (!active) begin
            armed_d = 1'b0;
        end else if (svc_we) begin
            if (svc_data == KEY_A) begin
                armed_d = 1'b1;
            end else if (svc_data == KEY_B && armed_q) begin
                kick_o  = 1'b1;
                armed_d = 1'b0;
            end else begin
                bad_o   = 1'b1;
                armed_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end
endmodule

// File: rtl/wdog_lock_top.sv
`timescale 1ns/1ps
// Lockable watchdog: count, warn, then force reset with breadcrumb capture.
module wdog_lock_top
    import wdog_pkg::*;
#(
    parameter int TW        = 16,
    parameter int RW        = 32,
    parameter int GRACE_CYC = 2000,
    parameter int HOLD_CYC  = 16
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          cfg_we,
    input  logic [TW-1:0] cfg_timeout,
    input  logic          cfg_two_stage,
    input  logic          cfg_enable,
    input  logic          lock_set,
    input  logic          svc_we,
    input  logic [15:0]   svc_data,
    input  logic          stat_clr,
    input  logic [RW-1:0] rtc_time,
    output logic          nmi_o,
    output logic          cpu_rst_o,
    output logic          per_rst_o,
    output logic          safe_o,
    output logic          locked_o,
    output logic [TW-1:0] timeout_o,
    output logic          enable_o,
    output logic [RW-1:0] crumb_o,
    output logic          stat_wd_o,
    output logic          stat_nmi_o
);
    localparam int PMAX = (GRACE_CYC > HOLD_CYC) ? GRACE_CYC : HOLD_CYC;
    localparam int PW   = $clog2(PMAX + 1);
    localparam logic [PW-1:0] GRACE_LD = PW'(GRACE_CYC - 1);
    localparam logic [PW-1:0] HOLD_LD  = PW'(HOLD_CYC - 1);

    generate
        if (HOLD_CYC < 16) begin : g_hold_too_short
            $error("HOLD_CYC must be at least 16");
        end
    endgenerate

    typedef struct packed {
        wd_state_e     st;
        logic [TW-1:0] cnt;
        logic [PW-1:0] ph;
        logic          stat_wd;
        logic          stat_nmi;
        logic [RW-1:0] crumb;
    } wd_reg_t;

    wd_reg_t q, d;

    logic          cfg_load, two_stage_q, kick, bad;
    logic          go_hold, via_nmi;

    wdog_cfg #(.TW(TW)) u_cfg (
        .clk          (clk),
        .por_n        (por_n),
        .cfg_we       (cfg_we),
        .cfg_timeout  (cfg_timeout),
        .cfg_two_stage(cfg_two_stage),
        .cfg_enable   (cfg_enable),
        .lock_set     (lock_set),
        .timeout_q    (timeout_o),
        .two_stage_q  (two_stage_q),
        .enable_q     (enable_o),
        .locked_q     (locked_o),
        .load_o       (cfg_load)
    );

    wdog_key #(.KW(16)) u_key (
        .clk     (clk),
        .por_n   (por_n),
        .active  (q.st == WD_RUN),
        .svc_we  (svc_we),
        .svc_data(svc_data),
        .kick_o  (kick),
        .bad_o   (bad)
    );

    always_comb begin
        d       = q;
        go_hold = 1'b0;
        via_nmi = 1'b0;
        if (stat_clr) begin
            d.stat_wd  = 1'b0;
            d.stat_nmi = 1'b0;
        end
        unique case (q.st)
            WD_IDLE: begin
                if (cfg_load && cfg_enable) begin
                    d.st  = WD_RUN;
                    d.cnt = cfg_timeout;
                end
            end
            WD_RUN: begin
                if (bad || (!kick && q.cnt == '0)) begin
                    if (two_stage_q) begin
                        d.st = WD_GRACE;
                        d.ph = GRACE_LD;
                    end else begin
                        go_hold = 1'b1;
                    end
                end else if (kick) begin
                    d.cnt = timeout_o;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            WD_GRACE: begin
                if (q.ph == '0) begin
                    go_hold = 1'b1;
                    via_nmi = 1'b1;
                end else begin
                    d.ph = q.ph - 1'b1;
                end
            end
            WD_HOLD: begin
                if (q.ph == '0) begin
                    d.st  = WD_RUN;
                    d.cnt = timeout_o;
                end else begin
                    d.ph = q.ph - 1'b1;
                end
            end
            default: d.st = WD_IDLE;
        endcase
        if (go_hold) begin
            d.st       = WD_HOLD;
            d.ph       = HOLD_LD;
            d.crumb    = rtc_time;
            d.stat_wd  = 1'b1;
            d.stat_nmi = via_nmi;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q <= '0;
        else        q <= d;
    end

    assign nmi_o      = (q.st == WD_GRACE);
    assign cpu_rst_o  = (q.st == WD_HOLD);
    assign per_rst_o  = (q.st == WD_HOLD);
    assign safe_o     = (q.st == WD_HOLD);
    assign crumb_o    = q.crumb;
    assign stat_wd_o  = q.stat_wd;
    assign stat_nmi_o = q.stat_nmi;
endmodule

// File: rtl/wdog_lock_chk.sv
`timescale 1ns/1ps
// Property checker bound to the watchdog top.
module wdog_lock_chk #(
    parameter int TW       = 16,
    parameter int RW       = 32,
    parameter int HOLD_CYC = 16
) (
    input logic          clk,
    input logic          por_n,
    input logic          locked_o,
    input logic [TW-1:0] timeout_o,
    input logic          nmi_o,
    input logic          cpu_rst_o,
    input logic [RW-1:0] crumb_o,
    input logic [RW-1:0] rtc_time,
    input logic          stat_wd_o
);
    localparam int HCW = $clog2(HOLD_CYC + 2);
    logic [HCW-1:0] hold_run;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                                   hold_run <= '0;
        else if (!cpu_rst_o)                          hold_run <= '0;
        else if (hold_run != HCW'(HOLD_CYC + 1))      hold_run <= hold_run + 1'b1;
    end

    a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!por_n)
        locked_o |=> locked_o);

    a_r1_timeout_frozen: assert property (@(posedge clk) disable iff (!por_n)
        locked_o |=> $stable(timeout_o));

    a_r5_grace_escalates: assert property (@(posedge clk) disable iff (!por_n)
        $fell(nmi_o) |-> cpu_rst_o);

    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!por_n)
        !(nmi_o && cpu_rst_o));

    a_r7_min_hold: assert property (@(posedge clk) disable iff (!por_n)
        $fell(cpu_rst_o) |-> (hold_run >= HCW'(HOLD_CYC)));

    a_r9_crumb_capture: assert property (@(posedge clk) disable iff (!por_n)
        $rose(cpu_rst_o) |-> (crumb_o == $past(rtc_time)));

    a_r10_flag_set: assert property (@(posedge clk) disable iff (!por_n)
        $rose(cpu_rst_o) |-> stat_wd_o);
endmodule

bind wdog_lock_top wdog_lock_chk #(.TW(TW), .RW(RW), .HOLD_CYC(HOLD_CYC)) u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .locked_o (locked_o),
    .timeout_o(timeout_o),
    .nmi_o    (nmi_o),
    .cpu_rst_o(cpu_rst_o),
    .crumb_o  (crumb_o),
    .rtc_time (rtc_time),
    .stat_wd_o(stat_wd_o)
);

// File: tb/wdog_lock_top_tb.sv
`timescale 1ns/1ps
module wdog_lock_top_tb;
    localparam int TW = 16, RW = 32, GR = 40, HD = 16;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          cfg_we = 1'b0, cfg_two_stage = 1'b0, cfg_enable = 1'b0;
    logic [TW-1:0] cfg_timeout = '0;
    logic          lock_set = 1'b0, svc_we = 1'b0, stat_clr = 1'b0;
    logic [15:0]   svc_data = '0;
    logic [RW-1:0] rtc_time = '0;
    logic          nmi_o, cpu_rst_o, per_rst_o, safe_o, locked_o, enable_o;
    logic          stat_wd_o, stat_nmi_o;
    logic [TW-1:0] timeout_o;
    logic [RW-1:0] crumb_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdog_lock_top #(.TW(TW), .RW(RW), .GRACE_CYC(GR), .HOLD_CYC(HD)) u_dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_por();
        @(negedge clk);
        por_n = 1'b0; cfg_we = 0; lock_set = 0; svc_we = 0; stat_clr = 0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cfg_wr(input logic [TW-1:0] t, input logic two, input logic en);
        @(negedge clk);
        cfg_we = 1; cfg_timeout = t; cfg_two_stage = two; cfg_enable = en;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic lock();
        @(negedge clk); lock_set = 1;
        @(negedge clk); lock_set = 0;
    endtask

    task automatic svc(input logic [15:0] v);
        @(negedge clk); svc_we = 1; svc_data = v;
        @(negedge clk); svc_we = 0;
    endtask

    task automatic kick();
        svc(16'h5555);
        svc(16'hAAAA);
    endtask

    task automatic wait_alarm(output int k);
        k = 0;
        while (!(nmi_o || cpu_rst_o) && k < 5000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic count_hold(output int k);
        k = 0;
        while (cpu_rst_o && k < 5000) begin
            if (!(per_rst_o && safe_o)) k = 9999;
            k++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        do_por();
        chk("R11 alarms low", {nmi_o, cpu_rst_o, per_rst_o, safe_o}, 0);
        chk("R11 lock clear", locked_o, 0);
        chk("R11 crumb zero", crumb_o, 0);
        chk("R11 flags zero", {stat_wd_o, stat_nmi_o}, 0);
        chk("R11 idle enable", enable_o, 0);
    endtask

    task automatic t_disabled();
        bit seen = 0;
        do_por();
        cfg_wr(16'd5, 1'b0, 1'b0);
        repeat (60) begin @(negedge clk); if (nmi_o || cpu_rst_o) seen = 1; end
        chk("R12 disabled never alarms", seen, 0);
        cfg_wr(16'd7, 1'b0, 1'b1);
        chk("R1 second write timeout", timeout_o, 16'd5);
        chk("R1 second write enable", enable_o, 0);
        repeat (60) begin @(negedge clk); if (nmi_o || cpu_rst_o) seen = 1; end
        chk("R12 still idle after rewrite", seen, 0);
    endtask

    task automatic t_lock_first();
        do_por();
        lock();
        chk("R2 lock set", locked_o, 1);
        cfg_wr(16'd10, 1'b0, 1'b1);
        chk("R2 write ignored timeout", timeout_o, 0);
        chk("R2 write ignored enable", enable_o, 0);
        stat_clr = 1; @(negedge clk); stat_clr = 0;
        chk("R2 lock sticky", locked_o, 1);
        do_por();
        chk("R2 por clears lock", locked_o, 0);
    endtask

    task automatic t_single();
        int k;
        do_por();
        rtc_time = 32'hCAFE_0001;
        cfg_wr(16'd20, 1'b0, 1'b1);
        lock();
        cfg_wr(16'd3, 1'b1, 1'b0);
        chk("R1 locked timeout kept", timeout_o, 16'd20);
        do_por();
        cfg_wr(16'd20, 1'b0, 1'b1);
        wait_alarm(k);
        chk("R3 expiry delay", k, 21);
        chk("R6 no interrupt", nmi_o, 0);
        chk("R7 resets and safe", {cpu_rst_o, per_rst_o, safe_o}, 3'b111);
        chk("R9 crumb captured", crumb_o, 32'hCAFE_0001);
        chk("R10 direct flags", {stat_wd_o, stat_nmi_o}, 2'b10);
        rtc_time = 32'h1234_5678;
        count_hold(k);
        chk("R7 hold length", k, HD);
        chk("R9 crumb kept", crumb_o, 32'hCAFE_0001);
        wait_alarm(k);
        chk("R8 reload after release", k, 21);
        chk("R6 second expiry direct", {nmi_o, cpu_rst_o}, 2'b01);
        chk("R9 recapture", crumb_o, 32'h1234_5678);
        stat_clr = 1; @(negedge clk); stat_clr = 0;
        count_hold(k);
        chk("R10 clear flags", {stat_wd_o, stat_nmi_o}, 0);
        chk("R10 clear keeps crumb", crumb_o, 32'h1234_5678);
    endtask

    task automatic t_two_stage();
        int k;
        bit seen = 0;
        do_por();
        rtc_time = 32'h0000_BEEF;
        cfg_wr(16'd20, 1'b1, 1'b1);
        lock();
        for (int i = 0; i < 8; i++) begin
            repeat (10) begin @(negedge clk); if (nmi_o || cpu_rst_o) seen = 1; end
            kick();
        end
        chk("R3 serviced stays quiet", seen, 0);
        wait_alarm(k);
        chk("R3 delay after service", k, 21);
        chk("R5 interrupt first", {nmi_o, cpu_rst_o}, 2'b10);
        k = 1;
        kick();
        if (nmi_o) k += 4;
        while (nmi_o && k < 5000) begin
            @(negedge clk);
            if (nmi_o) k++;
        end
        chk("R5 grace length despite service", k, GR);
        chk("R5 reset follows", cpu_rst_o, 1);
        chk("R10 interrupt path flag", {stat_wd_o, stat_nmi_o}, 2'b11);
        chk("R9 crumb two-stage", crumb_o, 32'h0000_BEEF);
        do_por();
        chk("R9 por clears crumb", crumb_o, 0);
    endtask

    task automatic t_bad_key();
        do_por();
        cfg_wr(16'd30, 1'b1, 1'b1);
        svc(16'h1234);
        chk("R4 wrong key escalates", nmi_o, 1);
        do_por();
        cfg_wr(16'd30, 1'b0, 1'b1);
        svc(16'hAAAA);
        chk("R4 unarmed second word", cpu_rst_o, 1);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_lock_first();
        t_single();
        t_two_stage();
        t_bad_key();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule